// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of an external signal. It counts the rising edges of that signal over a fixed gate window, and the window length is a whole number of reference ticks. Software first writes a configuration that sets a two-bit measurement mode and a two-bit window code. It then issues a start command. The block counts only while the window is open. When the window closes, it stores the edge count on its result output and raises a completion flag.

Three system power states force the counted input off: halt, backup and oscillator-loop stop. The input is also off after reset until a measurement is started. If any of these power states becomes active during a window, the measurement is abandoned and the completion flag is not raised.

Top module: `gate_freq_counter`

## Requirements
- R1: After reset `done` is 0 and `count_out` is 0.
- R2: The window closes on the Nth `ref_tick` pulse after the start. N depends on the window code written to `cfg_gate`: 2'b00 gives N=1, 2'b01 gives N=4, 2'b10 gives N=8 and 2'b11 gives N=32.
- R3: A start begins a measurement only when the stored mode is 2'b00. With any other mode code, `done` stays 0 and `count_out` stays 0.
- R4: Without a start command, input edges and `ref_tick` pulses do not change `done` or `count_out`.
- R5: When the window closes, `done` becomes 1 on the same clock edge. At that edge `count_out` takes the number of rising edges of `sig_in` seen during the window.
- R6: A start clears `done` and `count_out`. A start during an open window restarts the window and the count from zero.
- R7: If `sys_halt`, `sys_backup` or `sys_pll_stop` is high during a window, the measurement is abandoned and `done` stays 0. A start issued while any of them is high does not open a window.
- R8: The edge count saturates at 2^CNT_W-1 and does not wrap.
- R9: A configuration write during an open window does not change the length or the counting of that window. It takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Measurement mode code (2'b00 means count) |
| cfg_gate | input | 2 | Window length code |
| start | input | 1 | Start-measurement command |
| sys_halt | input | 1 | Halt state: input disabled |
| sys_backup | input | 1 | Backup state: input disabled |
| sys_pll_stop | input | 1 | Oscillator-loop stop state: input disabled |
| sig_in | input | 1 | Asynchronous signal to be measured |
| ref_tick | input | 1 | One-cycle reference time tick |
| count_out | output | CNT_W | Edge count of the last completed window |
| done | output | 1 | Count-end flag |

## Verification
Every cycle, the assertions check the following:
- a start always clears the flag;
- the flag rises only out of an open window, and only after exactly the number of ticks its code selects;
- a disabled input closes the window without the flag;
- windows open only in mode 2'b00;
- the result and count hold between measurements;
- the count holds at its ceiling.

Only the bench's scenarios can show the following:
- the exact number of edges stored for given input patterns;
- that restarts and mid-window configuration writes produce the right count;
- that edges without a start leave the outputs unchanged.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  localparam int TICK_W = 6;
  localparam logic [1:0] MODE_FREQ = 2'b00;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} gfc_state_t;

  function automatic logic [TICK_W-1:0] gate_ticks(input logic [1:0] code);
    case (code)
      2'b00:   gate_ticks = TICK_W'(1);
      2'b01:   gate_ticks = TICK_W'(4);
      2'b10:   gate_ticks = TICK_W'(8);
      default: gate_ticks = TICK_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/gfc_sync_edge.sv
module gfc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = async_in;
      end else begin : g_rest
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/gfc_gate_timer.sv
module gfc_gate_timer
  import gfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] code,
  input  logic       tick_en,
  output logic       expire
);
  logic [TICK_W-1:0] limit_q, limit_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;

  always_comb begin
    limit_d = limit_q;
    cnt_d   = cnt_q;
    if (load) begin
      limit_d = gate_ticks(code);
      cnt_d   = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= TICK_W'(1);
      cnt_q   <= '0;
    end else begin
      limit_q <= limit_d;
      cnt_q   <= cnt_d;
    end
  end

  assign expire = tick_en && (cnt_q == (limit_q - TICK_W'(1)));
endmodule

// File: rtl/gfc_sat_counter.sv
module gfc_sat_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_comb begin
    d = q;
    if (clr)                 d = '0;
    else if (inc && q != MAX) d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/gate_freq_counter.sv
module gate_freq_counter
  import gfc_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_gate,
  input  logic             start,
  input  logic             sys_halt,
  input  logic             sys_backup,
  input  logic             sys_pll_stop,
  input  logic             sig_in,
  input  logic             ref_tick,
  output logic [CNT_W-1:0] count_out,
  output logic             done
);
  gfc_state_t       state_q, state_d;
  logic [1:0]       mode_q, mode_d;
  logic [1:0]       gate_q, gate_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] result_q, result_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_en, running, go, rise, expire, close;

  assign in_en   = ~(sys_halt | sys_backup | sys_pll_stop);
  assign running = (state_q == ST_RUN);
  assign go      = start && in_en && (mode_q == MODE_FREQ);
  assign close   = running && in_en && !start && expire;

  gfc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sig_in & in_en),
    .rise     (rise)
  );

  gfc_gate_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (go),
    .code    (gate_q),
    .tick_en (running && ref_tick && !start),
    .expire  (expire)
  );

  gfc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .inc   (running && in_en && rise),
    .q     (cnt_q),
    .d     (cnt_d)
  );

  always_comb begin
    mode_d = mode_q;
    gate_d = gate_q;
    if (cfg_we) begin
      mode_d = cfg_mode;
      gate_d = cfg_gate;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_RUN;
      ST_RUN: begin
        if (!in_en)      state_d = ST_IDLE;
        else if (start)  state_d = go ? ST_RUN : ST_IDLE;
        else if (expire) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d   = done_q;
    result_d = result_q;
    if (start) begin
      done_d   = 1'b0;
      result_d = '0;
    end else if (close) begin
      done_d   = 1'b1;
      result_d = cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_FREQ;
      gate_q   <= 2'b00;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      gate_q   <= gate_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  assign count_out = result_q;
  assign done      = done_q;
endmodule

// File: rtl/gfc_checker.sv
module gfc_checker
  import gfc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ref_tick,
  input logic             done,
  input logic             running,
  input logic             in_en,
  input logic [1:0]       mode_q,
  input logic [1:0]       gate_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] count_out
);
  logic [6:0] seen_q;
  logic [1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      snap_q <= 2'b00;
    end else if (start) begin
      seen_q <= '0;
      snap_q <= gate_q;
    end else if (running && ref_tick) begin
      seen_q <= seen_q + 7'd1;
    end
  end

  assert_window_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (seen_q == 7'(gate_ticks(snap_q))));

  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(start && in_en && mode_q == MODE_FREQ));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(count_out) && $stable(cnt_q)));

  assert_done_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(running) && !running));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !in_en) |=> (!running && !done));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && !start) |=> (cnt_q == {CNT_W{1'b1}}));
endmodule

bind gate_freq_counter gfc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ref_tick  (ref_tick),
  .done      (done),
  .running   (running),
  .in_en     (in_en),
  .mode_q    (mode_q),
  .gate_q    (gate_q),
  .cnt_q     (cnt_q),
  .count_out (count_out)
);

// File: tb/tb_gate_freq_counter.sv
module tb_gate_freq_counter;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [1:0] cfg_gate = 2'b00;
  logic start = 1'b0;
  logic sys_halt = 1'b0;
  logic sys_backup = 1'b0;
  logic sys_pll_stop = 1'b0;
  logic sig_in = 1'b0;
  logic ref_tick = 1'b0;
  logic [CNT_W-1:0] count_out;
  logic done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gate_freq_counter #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_gate(cfg_gate), .start(start), .sys_halt(sys_halt),
    .sys_backup(sys_backup), .sys_pll_stop(sys_pll_stop),
    .sig_in(sig_in), .ref_tick(ref_tick), .count_out(count_out), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic [1:0] g);
    @(negedge clk); cfg_mode = m; cfg_gate = g; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sig_in = 1'b1;
      @(negedge clk);
      @(negedge clk); sig_in = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 count", count_out, 0);
  endtask

  task automatic t_gate(input logic [1:0] code, input int n, input int k);
    write_cfg(2'b00, code);
    pulse_start();
    edges(k);
    ticks(n - 1);
    chk("R2 done before last tick", done, 0);
    ticks(1);
    chk("R2 R5 done at last tick", done, 1);
    chk("R5 count", count_out, k);
  endtask

  task automatic t_no_start();
    edges(3);
    ticks(5);
    chk("R4 done held", done, 1);
    chk("R4 count held", count_out, 7);
  endtask

  task automatic t_mode();
    for (int m = 1; m < 4; m++) begin
      write_cfg(2'(m), 2'b00);
      pulse_start();
      chk("R6 start clears done", done, 0);
      edges(3);
      ticks(32);
      chk("R3 no done", done, 0);
      chk("R3 no count", count_out, 0);
    end
  endtask

  task automatic t_restart();
    write_cfg(2'b00, 2'b01);
    pulse_start();
    edges(4);
    ticks(2);
    pulse_start();
    chk("R6 restart done", done, 0);
    edges(2);
    ticks(3);
    chk("R6 window restarted", done, 0);
    ticks(1);
    chk("R6 done after restart", done, 1);
    chk("R6 count after restart", count_out, 2);
  endtask

  task automatic t_abort();
    write_cfg(2'b00, 2'b01);
    for (int s = 0; s < 3; s++) begin
      pulse_start();
      edges(2);
      ticks(1);
      @(negedge clk);
      sys_halt = (s == 0); sys_backup = (s == 1); sys_pll_stop = (s == 2);
      @(negedge clk);
      sys_halt = 1'b0; sys_backup = 1'b0; sys_pll_stop = 1'b0;
      ticks(5);
      chk("R7 abort no done", done, 0);
      chk("R7 abort count", count_out, 0);
    end
    @(negedge clk); sys_backup = 1'b1;
    pulse_start();
    ticks(4);
    @(negedge clk); sys_backup = 1'b0;
    ticks(4);
    chk("R7 start while disabled", done, 0);
  endtask

  task automatic t_sat();
    write_cfg(2'b00, 2'b00);
    pulse_start();
    edges(70);
    ticks(1);
    chk("R8 done", done, 1);
    chk("R8 saturated", count_out, 63);
  endtask

  task automatic t_cfg_mid();
    write_cfg(2'b00, 2'b00);
    pulse_start();
    write_cfg(2'b10, 2'b11);
    edges(2);
    ticks(1);
    chk("R9 window kept", done, 1);
    chk("R9 count kept", count_out, 2);
    write_cfg(2'b00, 2'b01);
    pulse_start();
    ticks(3);
    chk("R9 new code used", done, 0);
    ticks(1);
    chk("R9 new code closes", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_gate(2'b00, 1, 3);
    t_gate(2'b01, 4, 5);
    t_gate(2'b10, 8, 0);
    t_gate(2'b11, 32, 7);
    t_no_start();
    t_mode();
    t_restart();
    t_abort();
    t_sat();
    t_cfg_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule